// File: doc/BRIEF.md
# Synchronous Burst SRAM

A clocked static memory with registered address, control and write-data inputs and a small burst sequencer that walks the four words of a cache line. Two address strobes start accesses. The processor strobe always starts a read, and can also open a two-cycle write. The controller strobe starts a read or a write, chosen by a global write line. Once a burst is open, a low advance input steps the two low address bits in interleaved order. A high advance input holds the address, which inserts a wait state.

The array is built from independent 9-bit lanes, two by default, and each lane has its own write enable. Chip enable is sampled only when a base address is loaded. Read data is registered. The output-valid flag stands in for the output driver: when the flag is low, the output counts as high impedance. The array depth is a parameter.

Top module: `sbsram_core`

## Requirements
- R1: While reset is asserted, `rdata_vld` is low and `rdata` is all zeros.
- R2: When `cpu_stb_n` is low at a rising edge, `addr` becomes the burst base and the cycle is a read. This holds whatever `we_n`, `ctl_stb_n` and `lane_we_n` are, and no lane is written.
- R3: A processor-strobe write takes two cycles. First, `cpu_stb_n` is low with the address. Next, both strobes are high, `adv_n` is high and at least one lane enable is low. That second cycle writes `wdata` into the enabled lanes at the loaded address.
- R4: When `ctl_stb_n` is low and `cpu_stb_n` is high, `addr` becomes the burst base. With `we_n` high the cycle is a read. With `we_n` low, the enabled lanes are written with that cycle's `wdata` at `addr`. If `we_n` is low and no lane is enabled, the cycle does nothing.
- R5: `ce_n` is sampled only in strobe cycles. Low selects the device for the whole burst. A change of `ce_n` in later cycles has no effect.
- R6: In a cycle with both strobes high, a selected device with `adv_n` low steps the beat count before that cycle's access. The low two address bits are the base low bits XOR the beat count, so a start of 2 gives 2, 3, 0, 1. The upper address bits never change within a burst.
- R7: In a cycle with both strobes high and `adv_n` high, the address is held, and the cycle repeats its access at the same word.
- R8: After the fourth beat, one more step returns the address to the burst's starting word.
- R9: `lane_we_n[0]` guards `wdata[8:0]` and `lane_we_n[1]` guards `wdata[17:9]`. A lane whose enable is high keeps its old contents.
- R10: Read data appears on `rdata` just after the rising edge that registers the address or the step. `rdata_vld` is high only when `oe_n` is low, the device is selected and the cycle is a read.
- R11: While the device is deselected, `lane_we_n` and `adv_n` are ignored, no word changes, and `rdata_vld` stays low.
- R12: In a cycle with both strobes high, a selected device writes at the current address (after any step) if any lane enable is low. Otherwise it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input register captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| cpu_stb_n | input | 1 | Processor address strobe, active low, highest priority |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait state |
| ce_n | input | 1 | Chip enable, active low, sampled only with a strobe |
| we_n | input | 1 | Global write line for controller-strobe cycles, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low, bit 0 is the lower lane |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_vld | output | 1 | Output driven; low stands for high impedance |

## Verification
The properties assume that every input is at a known level at each rising edge after reset, and that `addr` stays inside the array depth. They also assume that `oe_n` is sampled only after it has settled, since it gates the valid flag without a register. The bench drives each input once per cycle, a quarter period after the edge, and draws addresses only within the reduced array. It first writes every word, so every later read has a defined value. Directed cycles first cover strobe priority, wrap-around, wait states, deselection and single-lane writes. Seeded random strobes, enables and data then follow.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sb_op_e;
endpackage

// File: rtl/sbsram_seq.sv
module sbsram_seq
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BURST_W = 2,
  parameter int LANES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] acc_addr,
  output sb_op_e            acc_op,
  output logic [LANES-1:0]  lane_wr
);
  localparam int HI_LSB = BURST_W;

  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic               sel_q, sel_d;
  logic [ADDR_W-1:0]  cur_addr;
  logic               any_lane;

  assign any_lane = |(~lane_we_n);
  assign cnt_inc  = cnt_q + BURST_W'(1);
  // address of the word the burst currently points to
  assign cur_addr = {base_q[ADDR_W-1:HI_LSB], base_q[BURST_W-1:0] ^ cnt_q};

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    sel_d    = sel_q;
    acc_op   = OP_IDLE;
    acc_addr = cur_addr;
    if (!cpu_stb_n) begin
      // processor strobe: load and read, write line ignored
      base_d   = addr;
      cnt_d    = '0;
      sel_d    = !ce_n;
      acc_addr = addr;
      acc_op   = sel_d ? OP_READ : OP_IDLE;
    end else if (!ctl_stb_n) begin
      base_d   = addr;
      cnt_d    = '0;
      sel_d    = !ce_n;
      acc_addr = addr;
      if (sel_d) begin
        if (we_n)          acc_op = OP_READ;
        else if (any_lane) acc_op = OP_WRITE;
      end
    end else if (sel_q) begin
      if (!adv_n) begin
        cnt_d    = cnt_inc;
        acc_addr = {cur_addr[ADDR_W-1:HI_LSB], base_q[BURST_W-1:0] ^ cnt_inc};
      end
      acc_op = any_lane ? OP_WRITE : OP_READ;
    end
  end

  assign lane_wr = (acc_op == OP_WRITE) ? ~lane_we_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/sbsram_lane.sv
module sbsram_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= mem[addr];
  end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    adv_n,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_vld
);
  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] acc_addr;
  sb_op_e            acc_op;
  logic [LANES-1:0]  lane_wr;
  logic              rd_q;
  logic [DATA_W-1:0] lane_q;

  sbsram_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES)) seq_i (
    .clk(clk), .rst_n(rst_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
    .adv_n(adv_n), .ce_n(ce_n), .we_n(we_n), .lane_we_n(lane_we_n),
    .addr(addr), .acc_addr(acc_addr), .acc_op(acc_op), .lane_wr(lane_wr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbsram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) lane_i (
      .clk(clk), .rst_n(rst_n), .wr(lane_wr[g]), .rd(acc_op == OP_READ),
      .addr(acc_addr), .wdata(wdata[g*LANE_W +: LANE_W]),
      .rdata(lane_q[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= (acc_op == OP_READ);
  end

  assign rdata     = lane_q;
  assign rdata_vld = rd_q && !oe_n;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_seq_chk #(
  parameter int ADDR_W  = 10,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_stb_n,
  input logic              ctl_stb_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              sel_q
);
  assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stb_n |=> cur_addr == $past(addr));

  assert_ctl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stb_n && !ctl_stb_n) |=> cur_addr == $past(addr));

  assert_ce_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stb_n && ctl_stb_n) |=> $stable(sel_q));

  assert_step_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stb_n && ctl_stb_n && !adv_n && sel_q) |=>
      (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]))
      && (cur_addr != $past(cur_addr)));

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stb_n && ctl_stb_n && adv_n && sel_q) |=> $stable(cur_addr));

  assert_desel_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stb_n && ctl_stb_n && !sel_q) |=> $stable(cur_addr));
endmodule

module sbsram_out_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_stb_n,
  input logic ce_n,
  input logic oe_n,
  input logic rdata_vld
);
  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!rdata_vld);
  end

  assert_cpu_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !ce_n) |=> (rdata_vld == !oe_n));

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_vld);

  assert_desel_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && ce_n) |=> !rdata_vld);
endmodule

bind sbsram_seq sbsram_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) seq_chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
  .adv_n(adv_n), .addr(addr), .cur_addr(cur_addr), .sel_q(sel_q)
);

bind sbsram_core sbsram_out_chk out_chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_stb_n(cpu_stb_n), .ce_n(ce_n),
  .oe_n(oe_n), .rdata_vld(rdata_vld)
);

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, adv_n = 1'b1, ce_n = 1'b1;
  logic          we_n = 1'b1, oe_n = 1'b0;
  logic [1:0]    lane_we_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference state
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            m_sel = 0;
  bit            m_rd = 0;
  logic [DW-1:0] m_data = '0;

  always #(CLK_P/2) clk = ~clk;

  sbsram_core #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
    .adv_n(adv_n), .ce_n(ce_n), .we_n(we_n), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 18'h0A5 + 18'h1234);
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [1:0] c);
    return {b[AW-1:2], b[1:0] ^ c};
  endfunction

  task automatic model_edge();
    bit wr = 0;
    bit rd = 0;
    logic [AW-1:0] a;
    if (!cpu_stb_n) begin
      m_base = addr; m_cnt = 0; m_sel = !ce_n; rd = m_sel;
    end else if (!ctl_stb_n) begin
      m_base = addr; m_cnt = 0; m_sel = !ce_n;
      if (m_sel) begin
        if (we_n) rd = 1;
        else if (lane_we_n != 2'b11) wr = 1;
      end
    end else if (m_sel) begin
      if (!adv_n) m_cnt = m_cnt + 2'd1;
      if (lane_we_n != 2'b11) wr = 1; else rd = 1;
    end
    a = beat_addr(m_base, m_cnt);
    if (wr) begin
      if (!lane_we_n[0]) ref_mem[a][8:0]  = wdata[8:0];
      if (!lane_we_n[1]) ref_mem[a][17:9] = wdata[17:9];
    end
    m_rd = rd;
    if (rd) m_data = ref_mem[a];
  endtask

  task automatic check_out();
    logic exp_v;
    exp_v = m_rd && !oe_n;
    n_chk++;
    if (rdata_vld !== exp_v) begin
      n_bad++;
      $display("FAIL %s: rdata_vld actual %0b expected %0b at %0t", cur_req, rdata_vld, exp_v, $time);
    end
    if (exp_v) begin
      n_chk++;
      if (rdata !== m_data) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h at %0t", cur_req, rdata, m_data, $time);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #(CLK_P/4);
    check_out();
  endtask

  task automatic drv(input logic cpu, input logic ctl, input logic adv, input logic ce,
                     input logic we, input logic [1:0] lw, input logic oe,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_stb_n = cpu; ctl_stb_n = ctl; adv_n = adv; ce_n = ce;
    we_n = we; lane_we_n = lw; oe_n = oe; addr = a; wdata = d;
    tick();
  endtask

  task automatic idle_adv(input logic adv, input logic [1:0] lw, input logic [DW-1:0] d);
    drv(1, 1, adv, 0, 1, lw, 0, addr, d);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

    // R1: reset state
    repeat (2) @(posedge clk);
    #(CLK_P/4);
    cur_req = "R1";
    n_chk++;
    if (rdata_vld !== 1'b0 || rdata !== '0) begin
      n_bad++;
      $display("FAIL R1: vld/rdata actual %0b/%h expected 0/0", rdata_vld, rdata);
    end
    rst_n = 1'b1;
    tick();

    // R4: fill every word with controller-strobe writes, then a controller read
    cur_req = "R4";
    for (int a = 0; a < DEPTH; a++) drv(1, 0, 1, 0, 0, 2'b00, 0, AW'(a), pat(a));
    drv(1, 0, 1, 0, 1, 2'b11, 0, 6'd5, '0);
    drv(1, 0, 1, 0, 0, 2'b11, 0, 6'd7, 18'h3FFFF);   // write line low, no lane: idle
    drv(1, 0, 1, 0, 1, 2'b11, 0, 6'd7, '0);

    // R6 / R8: interleaved burst from low bits 2, then wrap
    cur_req = "R6";
    drv(0, 1, 1, 0, 1, 2'b11, 0, 6'd14, '0);
    idle_adv(0, 2'b11, '0);
    idle_adv(0, 2'b11, '0);
    idle_adv(0, 2'b11, '0);
    cur_req = "R8";
    idle_adv(0, 2'b11, '0);

    // R7: wait state repeats the same word
    cur_req = "R7";
    idle_adv(1, 2'b11, '0);
    idle_adv(1, 2'b11, '0);
    idle_adv(0, 2'b11, '0);

    // R5: chip enable toggled mid-burst has no effect
    cur_req = "R5";
    drv(1, 1, 0, 1, 1, 2'b11, 0, 6'd0, '0);
    drv(1, 1, 1, 1, 1, 2'b11, 0, 6'd0, '0);

    // R3 / R9: two-cycle processor write, lower lane only
    cur_req = "R3";
    drv(0, 1, 1, 0, 1, 2'b11, 1, 6'd9, '0);
    drv(1, 1, 1, 0, 1, 2'b10, 1, 6'd0, 18'h2AB55);
    cur_req = "R9";
    drv(1, 0, 1, 0, 1, 2'b11, 0, 6'd9, '0);
    drv(1, 0, 1, 0, 0, 2'b01, 0, 6'd10, 18'h155AA);  // upper lane only
    drv(1, 0, 1, 0, 1, 2'b11, 0, 6'd10, '0);

    // R2: processor strobe wins, write line and lane enables ignored
    cur_req = "R2";
    drv(0, 0, 1, 0, 0, 2'b00, 0, 6'd12, 18'h3FFFF);
    drv(1, 0, 1, 0, 1, 2'b11, 0, 6'd12, '0);

    // R11: deselected device ignores lane enables and advance
    cur_req = "R11";
    drv(0, 1, 1, 1, 1, 2'b11, 0, 6'd20, '0);
    for (int i = 0; i < 4; i++) drv(1, 1, 0, 0, 0, 2'b00, 0, 6'd20, 18'h0F0F0);
    drv(1, 0, 1, 1, 0, 2'b00, 0, 6'd21, 18'h0F0F0);
    for (int a = 20; a < 24; a++) drv(1, 0, 1, 0, 1, 2'b11, 0, AW'(a), '0);

    // R10: output enable high hides a read
    cur_req = "R10";
    drv(1, 0, 1, 0, 1, 2'b11, 1, 6'd30, '0);
    drv(1, 1, 1, 0, 1, 2'b11, 0, 6'd30, '0);

    // R12: burst write beats after a controller read
    cur_req = "R12";
    drv(1, 0, 1, 0, 1, 2'b11, 0, 6'd33, '0);
    for (int i = 0; i < 4; i++) idle_adv(0, 2'b00, pat(100 + i));
    for (int i = 0; i < 4; i++) idle_adv(0, 2'b11, '0);

    // random traffic, all rules
    for (int i = 0; i < 3000; i++) begin
      logic cpu, ctl, ce, adv, we, oe;
      logic [1:0] lw;
      cpu = ($urandom_range(9) == 0) ? 1'b0 : 1'b1;
      ctl = ($urandom_range(9) == 0) ? 1'b0 : 1'b1;
      ce  = ($urandom_range(6) == 0) ? 1'b1 : 1'b0;
      adv = $urandom_range(1) ? 1'b1 : 1'b0;
      we  = $urandom_range(1) ? 1'b1 : 1'b0;
      oe  = ($urandom_range(6) == 0) ? 1'b1 : 1'b0;
      lw[0] = ($urandom_range(9) < 3) ? 1'b0 : 1'b1;
      lw[1] = ($urandom_range(9) < 3) ? 1'b0 : 1'b1;
      drv(cpu, ctl, adv, ce, we, lw, oe, AW'($urandom_range(DEPTH - 1)), DW'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule